// File: doc/BRIEF.md
# Shadowed Partial Reconfiguration Register Bank

This block keeps the configuration of a group of functional units in a coarse-grained array. Each unit has its own configuration space, and each space is split into several fields. A host reaches the block through a simple memory-mapped port. The port has a select, a read-not-write flag, a 15-bit address, 32-bit write data and 32-bit read data. Every field has its own address, so the host can retune one field of one unit without touching the rest.

Host writes land in a staging copy. The array is driven by a separate shadow copy, which is presented as one wide concatenated configuration bus. The shadow copy only changes when the `update` strobe is raised, and then it takes the whole staging copy in one clock edge. The array can keep running on a stable configuration while the host prepares the next one.

A small internal store holds several complete configurations in numbered slots. A command write saves the staging copy into a slot or brings a slot back into the staging copy. The transfer moves one field per cycle and raises `busy` while it runs.

Top module: `prcfg_bank`

## Requirements
- R1: A host write (`bus_sel`=1, `bus_rnw`=0) to address A < NF, where NF = NUM_UNITS*FIELDS_PER_UNIT and unit u, field f sits at A = u*FIELDS_PER_UNIT+f, stores `bus_wdata[FIELD_W-1:0]` into staged field A at that clock edge. All other staged fields keep their values.
- R2: Host writes to staged fields never change `cfg_bus`.
- R3: When `update` is 1 at a clock edge, `cfg_bus` takes the complete staging copy at that edge. Field i appears at `cfg_bus[i*FIELD_W +: FIELD_W]`. While `update` is 0, `cfg_bus` holds its value.
- R4: If a field write and `update` fall in the same cycle, the shadow copy receives the staged value from before the write.
- R5: A read (`bus_sel`=1, `bus_rnw`=1) of a field address returns the staged value, zero-extended, on `bus_rdata` in the following cycle. After any cycle without a read, `bus_rdata` is 0.
- R6: A read of any address at or above NF, including the command addresses, returns 0.
- R7: A write of slot index s to address 0x7FF0 (s in `bus_wdata[SLOT_W-1:0]`, s < NUM_SLOTS) starts a save. `busy` is 1 for exactly NF cycles, starting the cycle after the command, and field i moves in cycle i. At the end, slot s holds the staging copy.
- R8: A write of slot index s to address 0x7FF1 starts a restore with the same timing as R7, and at the end the staging copy equals slot s. `cfg_bus` does not change until the next `update`.
- R9: While `busy` is 1, host field writes and save/restore commands are ignored.
- R10: Reset (`rst_n`=0, asynchronous) clears the staging copy, the shadow copy, every store slot, `busy` and `bus_rdata`.
- R11: Writes to addresses at or above NF, other than the two command addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 15 | Field or command address |
| bus_wdata | input | 32 | Write data; the low FIELD_W bits are used for fields, the low SLOT_W bits for commands |
| bus_rdata | output | 32 | Registered read data |
| update | input | 1 | Copy the staging copy into the shadow copy |
| busy | output | 1 | Save or restore in progress |
| cfg_bus | output | NF*FIELD_W | Concatenated active configuration |

## Verification
The assertions take for granted that each host access is a one-cycle strobe, sampled at the edge where `bus_sel` is high. They also assume that `update` can arrive in any cycle, including during a save or restore. The bench holds every input steady from one falling edge to the next, so every access is a single-cycle event. Its random phase mixes field writes, reads of mapped and unmapped addresses, update pulses and commands that collide with a running transfer, so the ignore rules are exercised and not merely avoided.

// File: rtl/prcfg_pkg.sv
package prcfg_pkg;
  localparam int BUS_AW = 15;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] SAVE_CMD_ADDR = 15'h7FF0;
  localparam logic [BUS_AW-1:0] LOAD_CMD_ADDR = 15'h7FF1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SAVE = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_op_e;

  // flat field number of field fld in unit unit
  function automatic int unsigned field_addr(input int unsigned unit,
                                             input int unsigned fld,
                                             input int unsigned fpu);
    return unit * fpu + fld;
  endfunction

  // store word holding field idx of slot slot
  function automatic int unsigned store_addr(input int unsigned slot,
                                             input int unsigned idx,
                                             input int unsigned nf);
    return slot * nf + idx;
  endfunction
endpackage

// File: rtl/prcfg_host_dec.sv
module prcfg_host_dec
  import prcfg_pkg::*;
#(
  parameter int NUM_UNITS       = 4,
  parameter int FIELDS_PER_UNIT = 4,
  parameter int FIELD_W         = 8,
  parameter int NUM_SLOTS       = 4,
  localparam int NF     = NUM_UNITS * FIELDS_PER_UNIT,
  localparam int IDX_W  = (NF > 1) ? $clog2(NF) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               bus_sel,
  input  logic               bus_rnw,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  input  logic               seq_busy,
  output logic [NF-1:0]      field_we,
  output logic [FIELD_W-1:0] field_wval,
  output logic               save_go,
  output logic               load_go,
  output logic [SLOT_W-1:0]  cmd_slot,
  output logic               rd_hit,
  output logic [IDX_W-1:0]   rd_idx
);
  logic wr_ok;
  logic addr_is_field;
  logic slot_ok;
  logic unused_hi;

  assign wr_ok         = bus_sel && !bus_rnw && !seq_busy;
  assign addr_is_field = 32'(bus_addr) < NF;
  assign cmd_slot      = bus_wdata[SLOT_W-1:0];
  assign slot_ok       = 32'(cmd_slot) < NUM_SLOTS;
  assign field_wval    = bus_wdata[FIELD_W-1:0];
  assign unused_hi     = ^bus_wdata;

  assign save_go = wr_ok && (bus_addr == SAVE_CMD_ADDR) && slot_ok;
  assign load_go = wr_ok && (bus_addr == LOAD_CMD_ADDR) && slot_ok;

  assign rd_hit = bus_sel && bus_rnw && addr_is_field;
  assign rd_idx = bus_addr[IDX_W-1:0];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    for (genvar f = 0; f < FIELDS_PER_UNIT; f++) begin : g_fld
      localparam int unsigned FI = field_addr(u, f, FIELDS_PER_UNIT);
      assign field_we[FI] = wr_ok && (bus_addr == BUS_AW'(FI));
    end
  end
endmodule

// File: rtl/prcfg_stage.sv
module prcfg_stage #(
  parameter int NF      = 16,
  parameter int FIELD_W = 8,
  parameter int IDX_W   = 4,
  localparam int CW     = NF * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NF-1:0]      field_we,
  input  logic [FIELD_W-1:0] field_wval,
  input  logic               ld_en,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [FIELD_W-1:0] ld_val,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [FIELD_W-1:0] rd_val,
  output logic [CW-1:0]      stage_flat
);
  for (genvar g = 0; g < NF; g++) begin : g_word
    logic [FIELD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ld_en && (ld_idx == IDX_W'(g))) begin
        q <= ld_val;
      end else if (field_we[g]) begin
        q <= field_wval;
      end
    end
    assign stage_flat[g*FIELD_W +: FIELD_W] = q;
  end

  assign rd_val = stage_flat[rd_idx*FIELD_W +: FIELD_W];
endmodule

// File: rtl/prcfg_store.sv
module prcfg_store
  import prcfg_pkg::*;
#(
  parameter int NF        = 16,
  parameter int NUM_SLOTS = 4,
  parameter int FIELD_W   = 8,
  parameter int IDX_W     = 4,
  parameter int SLOT_W    = 2,
  localparam int CW       = NF * FIELD_W,
  localparam int DEPTH    = NUM_SLOTS * NF,
  localparam int MW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               save_go,
  input  logic               load_go,
  input  logic [SLOT_W-1:0]  cmd_slot,
  input  logic [CW-1:0]      stage_flat,
  output logic               busy,
  output logic               ld_en,
  output logic [IDX_W-1:0]   ld_idx,
  output logic [FIELD_W-1:0] ld_val,
  output logic               seq_step,
  output logic               seq_done
);
  seq_op_e            op;
  logic [IDX_W-1:0]   idx;
  logic [SLOT_W-1:0]  slot;
  logic [MW-1:0]      mem_addr;
  logic [FIELD_W-1:0] save_word;
  logic [FIELD_W-1:0] mem [DEPTH];

  assign mem_addr  = MW'(store_addr(32'(slot), 32'(idx), NF));
  assign save_word = stage_flat[idx*FIELD_W +: FIELD_W];
  assign seq_step  = (op != SEQ_IDLE);
  assign seq_done  = seq_step && (idx == IDX_W'(NF-1));
  assign busy      = seq_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op   <= SEQ_IDLE;
      idx  <= '0;
      slot <= '0;
    end else if (op == SEQ_IDLE) begin
      idx <= '0;
      if (save_go) begin
        op   <= SEQ_SAVE;
        slot <= cmd_slot;
      end else if (load_go) begin
        op   <= SEQ_LOAD;
        slot <= cmd_slot;
      end
    end else if (seq_done) begin
      op  <= SEQ_IDLE;
      idx <= '0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (op == SEQ_SAVE) begin
      mem[mem_addr] <= save_word;
    end
  end

  assign ld_en  = (op == SEQ_LOAD);
  assign ld_idx = idx;
  assign ld_val = mem[mem_addr];
endmodule

// File: rtl/prcfg_shadow.sv
module prcfg_shadow #(
  parameter int CW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          update,
  input  logic [CW-1:0] stage_flat,
  output logic [CW-1:0] cfg_bus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_bus <= '0;
    else if (update) cfg_bus <= stage_flat;
  end
endmodule

// File: rtl/prcfg_bank.sv
module prcfg_bank
  import prcfg_pkg::*;
#(
  parameter int NUM_UNITS       = 4,
  parameter int FIELDS_PER_UNIT = 4,
  parameter int FIELD_W         = 8,
  parameter int NUM_SLOTS       = 4,
  localparam int NF     = NUM_UNITS * FIELDS_PER_UNIT,
  localparam int IDX_W  = (NF > 1) ? $clog2(NF) : 1,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CW     = NF * FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_rnw,
  input  logic [14:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          update,
  output logic          busy,
  output logic [CW-1:0] cfg_bus
);
  logic [NF-1:0]      field_we;
  logic [FIELD_W-1:0] field_wval;
  logic               save_go;
  logic               load_go;
  logic [SLOT_W-1:0]  cmd_slot;
  logic               rd_hit;
  logic [IDX_W-1:0]   rd_idx;
  logic [FIELD_W-1:0] rd_val;
  logic [CW-1:0]      stage_flat;
  logic               ld_en;
  logic [IDX_W-1:0]   ld_idx;
  logic [FIELD_W-1:0] ld_val;
  logic               seq_step;
  logic               seq_done;

  prcfg_host_dec #(
    .NUM_UNITS(NUM_UNITS), .FIELDS_PER_UNIT(FIELDS_PER_UNIT),
    .FIELD_W(FIELD_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_dec (
    .bus_sel(bus_sel), .bus_rnw(bus_rnw), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .seq_busy(busy),
    .field_we(field_we), .field_wval(field_wval),
    .save_go(save_go), .load_go(load_go), .cmd_slot(cmd_slot),
    .rd_hit(rd_hit), .rd_idx(rd_idx)
  );

  prcfg_stage #(.NF(NF), .FIELD_W(FIELD_W), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .field_we(field_we), .field_wval(field_wval),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .rd_idx(rd_idx), .rd_val(rd_val), .stage_flat(stage_flat)
  );

  prcfg_store #(
    .NF(NF), .NUM_SLOTS(NUM_SLOTS), .FIELD_W(FIELD_W),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .save_go(save_go), .load_go(load_go), .cmd_slot(cmd_slot),
    .stage_flat(stage_flat), .busy(busy),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
    .seq_step(seq_step), .seq_done(seq_done)
  );

  prcfg_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .update(update),
    .stage_flat(stage_flat), .cfg_bus(cfg_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= 32'(rd_val);
    else bus_rdata <= '0;
  end
endmodule

// File: rtl/prcfg_bank_chk.sv
module prcfg_bank_chk #(
  parameter int NF = 16,
  parameter int CW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_rnw,
  input logic [14:0]   bus_addr,
  input logic [31:0]   bus_rdata,
  input logic          update,
  input logic          busy,
  input logic [CW-1:0] cfg_bus,
  input logic [CW-1:0] stage_flat,
  input logic [NF-1:0] field_we,
  input logic          seq_done
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (!busy) run_cnt <= '0;
    else run_cnt <= run_cnt + 16'd1;
  end

  // R3: shadow takes the staging copy on update
  p_update_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (cfg_bus == $past(stage_flat)));

  // R2 / R3: without update the active bus holds
  p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(cfg_bus));

  // R1: a host access writes at most one field
  p_one_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(field_we));

  // R9: no host field write while a transfer runs
  p_no_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (field_we == '0));

  // R7: a transfer never outlasts NF cycles
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < 16'(NF)));

  // R7: a transfer lasts exactly NF cycles
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == 16'(NF)));

  // R7: the last step ends the transfer
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !busy);

  // R6: unmapped reads return zero
  p_unmapped_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rnw && (32'(bus_addr) >= NF)) |=> (bus_rdata == '0));

  // R5: read data is zero after a cycle with no read
  p_idle_rdata_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rnw) |=> (bus_rdata == '0));
endmodule

bind prcfg_bank prcfg_bank_chk #(.NF(NF), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rnw(bus_rnw),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .update(update),
  .busy(busy), .cfg_bus(cfg_bus), .stage_flat(stage_flat),
  .field_we(field_we), .seq_done(seq_done)
);

// File: tb/prcfg_bank_tb.sv
`timescale 1ns/1ps
module prcfg_bank_tb;
  localparam int NU  = 4;
  localparam int FPU = 4;
  localparam int FW  = 8;
  localparam int NS  = 4;
  localparam int NF  = NU * FPU;
  localparam int CW  = NF * FW;
  localparam logic [14:0] A_SAVE = 15'h7FF0;
  localparam logic [14:0] A_LOAD = 15'h7FF1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_rnw = 1'b0;
  logic [14:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          update = 1'b0;
  logic [31:0]   bus_rdata;
  logic          busy;
  logic [CW-1:0] cfg_bus;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prcfg_bank #(.NUM_UNITS(NU), .FIELDS_PER_UNIT(FPU), .FIELD_W(FW), .NUM_SLOTS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .update(update), .busy(busy), .cfg_bus(cfg_bus)
  );

  // ---------------- behavioural reference model ----------------
  int m_stage [NF];
  int m_shadow[NF];
  int m_mem   [NS*NF];
  int m_busy, m_step, m_slot, m_is_load, m_rdata;

  function automatic logic [CW-1:0] pack_shadow();
    logic [CW-1:0] v = '0;
    for (int i = 0; i < NF; i++) v[i*FW +: FW] = FW'(m_shadow[i]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin m_stage[i] = 0; m_shadow[i] = 0; end
      for (int i = 0; i < NS*NF; i++) m_mem[i] = 0;
      m_busy = 0; m_step = 0; m_slot = 0; m_is_load = 0; m_rdata = 0;
    end else begin
      int a;
      a = int'(bus_addr);
      if (bus_sel && bus_rnw && a < NF) m_rdata = m_stage[a];
      else m_rdata = 0;
      if (update)
        for (int i = 0; i < NF; i++) m_shadow[i] = m_stage[i];
      if (m_busy != 0) begin
        if (m_is_load != 0) m_stage[m_step] = m_mem[m_slot*NF + m_step];
        else m_mem[m_slot*NF + m_step] = m_stage[m_step];
        if (m_step == NF-1) begin m_busy = 0; m_step = 0; end
        else m_step++;
      end else if (bus_sel && !bus_rnw) begin
        if (a < NF) m_stage[a] = int'(bus_wdata) & ((1 << FW) - 1);
        else if (bus_addr == A_SAVE || bus_addr == A_LOAD) begin
          m_busy = 1; m_step = 0; m_slot = int'(bus_wdata) % NS;
          m_is_load = (bus_addr == A_LOAD) ? 1 : 0;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (cfg_bus !== pack_shadow()) begin
        bad++;
        $display("FAIL R3/R4 model cfg_bus act=%h exp=%h", cfg_bus, pack_shadow());
      end
      total++;
      if (busy !== (m_busy != 0)) begin
        bad++;
        $display("FAIL R7/R8 model busy act=%0d exp=%0d", busy, m_busy);
      end
      total++;
      if (bus_rdata !== 32'(m_rdata)) begin
        bad++;
        $display("FAIL R5/R6 model rdata act=%h exp=%h", bus_rdata, m_rdata);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act,
                     input logic [CW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 0; bus_rnw = 0; bus_addr = '0; bus_wdata = '0; update = 0;
  endtask

  task automatic wr(input logic [14:0] a, input logic [31:0] d, input bit upd = 0);
    bus_sel = 1; bus_rnw = 0; bus_addr = a; bus_wdata = d; update = upd;
    @(negedge clk);
    idle();
  endtask

  task automatic pulse_update();
    update = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [14:0] a, input int exp, input string tag);
    bus_sel = 1; bus_rnw = 1; bus_addr = a;
    @(negedge clk);
    idle();
    chk(bus_rdata === 32'(exp), tag, CW'(bus_rdata), CW'(exp));
  endtask

  function automatic int pat(input int i);
    return (i * 16 + 1) & 8'hFF;
  endfunction

  logic [CW-1:0] want;
  logic [CW-1:0] held;

  initial begin
    int n;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10: reset state
    chk(cfg_bus === '0, "R10 cfg_bus after reset", cfg_bus, '0);
    chk(busy === 1'b0, "R10 busy after reset", CW'(busy), '0);
    rd(15'd3, 0, "R10 staged field after reset");

    // R1, R2: stage every field, upper data bits discarded
    for (int i = 0; i < NF; i++) wr(15'(i), 32'hFFFF_FF00 | 32'(pat(i)));
    chk(cfg_bus === '0, "R2 cfg_bus unchanged by writes", cfg_bus, '0);
    rd(15'd5, pat(5), "R1 R5 read field 5");
    rd(15'd15, pat(15), "R1 R5 read last field");

    // R3: update copies everything, field i at bits i*FW
    pulse_update();
    want = '0;
    for (int i = 0; i < NF; i++) want[i*FW +: FW] = FW'(pat(i));
    chk(cfg_bus === want, "R3 cfg_bus after update", cfg_bus, want);
    chk(cfg_bus[7*FW +: FW] === 8'd113, "R3 unit1 field3 position", CW'(cfg_bus[7*FW +: FW]), CW'(113));

    // R4: write and update in the same cycle
    wr(15'd0, 32'h55, 1'b1);
    chk(cfg_bus === want, "R4 shadow took pre-write value", cfg_bus, want);
    pulse_update();
    want[0 +: FW] = 8'h55;
    chk(cfg_bus === want, "R4 later update picks new value", cfg_bus, want);

    // R7, R9: save into slot 2, colliding accesses ignored
    wr(A_SAVE, 32'd2);
    n = 0;
    while (busy === 1'b1 && n < 100) begin
      if (n == 0) begin bus_sel = 1; bus_rnw = 0; bus_addr = 15'd5; bus_wdata = 32'h99; end
      if (n == 1) begin bus_sel = 1; bus_rnw = 0; bus_addr = A_LOAD; bus_wdata = 32'd1; end
      @(negedge clk);
      idle();
      n++;
    end
    chk(n == NF, "R7 busy length", CW'(n), CW'(NF));
    rd(15'd5, pat(5), "R9 field write during busy ignored");
    chk(busy === 1'b0, "R9 command during busy ignored", CW'(busy), '0);

    // R8: clear staging, restore slot 2
    for (int i = 0; i < NF; i++) wr(15'(i), 32'h0);
    rd(15'd5, 0, "R1 field cleared");
    held = cfg_bus;
    wr(A_LOAD, 32'd2);
    while (busy === 1'b1) @(negedge clk);
    chk(cfg_bus === held, "R8 cfg_bus unchanged by restore", cfg_bus, held);
    rd(15'd5, pat(5), "R8 restored field 5");
    rd(15'd0, 8'h55, "R8 restored field 0");

    // R6, R11: unmapped accesses
    wr(15'h0100, 32'hEE);
    wr(15'(NF), 32'hEE);
    rd(15'h0100, 0, "R6 unmapped read");
    rd(15'(NF), 0, "R6 read just past last field");
    rd(A_SAVE, 0, "R6 command address read");
    rd(15'd15, pat(15), "R11 unmapped write left field 15");
    chk(cfg_bus === held, "R11 unmapped write left cfg_bus", cfg_bus, held);

    // mixed random traffic, compared by the model every cycle
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom % 16);
      update = (($urandom % 8) == 0);
      if (r < 7) begin
        bus_sel = 1; bus_rnw = 0; bus_addr = 15'($urandom % NF); bus_wdata = $urandom;
      end else if (r < 10) begin
        bus_sel = 1; bus_rnw = 1;
        bus_addr = (r == 9) ? 15'($urandom) : 15'($urandom % NF);
      end else if (r == 10) begin
        bus_sel = 1; bus_rnw = 0; bus_addr = A_SAVE; bus_wdata = 32'($urandom % NS);
      end else if (r == 11) begin
        bus_sel = 1; bus_rnw = 0; bus_addr = A_LOAD; bus_wdata = 32'($urandom % NS);
      end else if (r == 12) begin
        bus_sel = 1; bus_rnw = 0; bus_addr = 15'(NF + int'($urandom % 200)); bus_wdata = $urandom;
      end
      @(negedge clk);
      idle();
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule